// File: doc/BRIEF.md
# PCM Transmit Serializer with Frame-Mode Detection

This block sends one 8-bit PCM word per frame on a serial line that can be tri-stated. A fast system clock samples two slow inputs: a transmit bit clock and a transmit frame sync. An encoder passes each new word in through a valid/ready port. The block drives a serial data bit and a separate output enable, and the enable controls the pad's tri-state buffer. When the enable is low, the data bit is held at 0.

Two framing styles are accepted. In the first, the frame sync pulse lasts one bit period. In the second, it lasts three or more bit periods. The block measures the width of every sync pulse in falling bit-clock edges and uses the result on the following frame. The two styles differ in when the enable turns on and off. With the long pulse, both the turn-on and the turn-off wait for whichever of two events comes later.

The word port has one slot. `pcm_ready` is high while the slot is empty. A transfer takes place in any cycle where `pcm_valid` and `pcm_ready` are both high. After a transfer, `pcm_ready` stays low until the next frame starts and moves the word into the shifter. While `pcm_ready` is low, the producer must hold its word and the slot is not written. If no new word arrives before a frame starts, the word from the last frame is sent again.

Top module: `pcm_tx_serializer`

## Requirements
- R1: While reset is asserted, and right after it is released, `sdata_oe` is 0, `sdata` is 0 and `pcm_ready` is 1. After reset the framing style is the one-bit-period pulse. A reset in the middle of a frame turns the output off.
- R2: In short mode, the frame starts at a falling bit-clock edge that sees frame sync high for the first time in that pulse. The next rising edge turns `sdata_oe` on and drives bit 7 (the sign bit). Each of the next seven rising edges drives the next lower bit, ending with bit 0.
- R3: In short mode, `sdata_oe` turns off at the first falling bit-clock edge after the eighth rising edge of the frame.
- R4: In long mode, the output turns on with bit 7 at the later of two events: the rising edge of frame sync, or a rising bit-clock edge. If the bit clock is already high when frame sync rises, the output turns on at once. The next seven rising edges shift out bits 6 down to 0.
- R5: In long mode, `sdata_oe` turns off at the later of two events: the falling bit-clock edge after the eighth rising edge, or frame sync going low. Until then `sdata` keeps bit 0.
- R6: Each sync pulse is measured in falling bit-clock edges seen while it is high. Exactly one such edge selects short mode. Three or more select long mode. The new mode applies from the next frame on.
- R7: Whenever `sdata_oe` is 0, `sdata` is 0.
- R8: `pcm_ready` is 1 exactly when the one-word slot is empty. After a transfer it goes to 0 and stays there until the next frame start. While it is 0, `pcm_data` is ignored.
- R9: A frame sends the word that sits in the slot when the frame starts. If no new word has been accepted since the last frame, the previous word is sent again.
- R10: While `sdata_oe` stays high, `sdata` changes only after a rising bit-clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples every other input |
| rst_n | input | 1 | Asynchronous reset, active low |
| bclk | input | 1 | Transmit bit clock, much slower than clk |
| fsync | input | 1 | Transmit frame sync |
| pcm_valid | input | 1 | A word is offered on pcm_data |
| pcm_data | input | 8 | PCM word; bit 7 is the sign bit and is sent first |
| pcm_ready | output | 1 | The slot is empty and can take a word |
| sdata | output | 1 | Serial PCM data; 0 while the output is disabled |
| sdata_oe | output | 1 | Tri-state enable for the serial data pad |

## Verification
Frames are sent with four kinds of sync pulse:
- a one-period pulse, which checks the enable one period late and the turn-off after the eighth bit;
- a three-period long pulse that rises together with the bit clock, which separates immediate turn-on from turn-on at the next edge;
- a ten-period long pulse, where frame sync outlasts the eighth bit, so the off point proves the later-of rule for turn-off;
- a long pulse that rises while the bit clock is low, which must wait for the next rising edge.

Pulses that flip the style are sent before the checked frames, to show that a new mode takes effect only on the next frame. Holding `pcm_valid` high against a full slot, and running a frame with no new word, tell apart the overwrite and repeat behaviours.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;

  typedef enum logic {
    FRM_SHORT = 1'b0,
    FRM_LONG  = 1'b1
  } frm_mode_e;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_ARM   = 2'd1,
    TX_SHIFT = 2'd2,
    TX_TAIL  = 2'd3
  } tx_state_e;

endpackage

// File: rtl/pcm_edge_sampler.sv
module pcm_edge_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic fsync,
  output logic bclk_lvl,
  output logic bclk_rise,
  output logic bclk_fall,
  output logic fs_lvl,
  output logic fs_rise,
  output logic fs_fall
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] b_sh, f_sh;
  logic         b_d, f_d;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          b_sh <= '0;
          f_sh <= '0;
        end else begin
          b_sh <= bclk;
          f_sh <= fsync;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          b_sh <= '0;
          f_sh <= '0;
        end else begin
          b_sh <= {b_sh[TOP-1:0], bclk};
          f_sh <= {f_sh[TOP-1:0], fsync};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_d <= 1'b0;
      f_d <= 1'b0;
    end else begin
      b_d <= b_sh[TOP];
      f_d <= f_sh[TOP];
    end
  end

  assign bclk_lvl  = b_sh[TOP];
  assign bclk_rise = b_sh[TOP] & ~b_d;
  assign bclk_fall = ~b_sh[TOP] & b_d;
  assign fs_lvl    = f_sh[TOP];
  assign fs_rise   = f_sh[TOP] & ~f_d;
  assign fs_fall   = ~f_sh[TOP] & f_d;
endmodule

// File: rtl/pcm_frame_mode_detect.sv
module pcm_frame_mode_detect
  import pcm_tx_pkg::*;
#(
  parameter int LONG_MIN = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bclk_fall,
  input  logic      fs_lvl,
  input  logic      fs_fall,
  output frm_mode_e mode,
  output logic      first_fall
);
  localparam int             CW    = $clog2(LONG_MIN + 1);
  localparam logic [CW-1:0]  SAT   = CW'(LONG_MIN);
  localparam logic [CW-1:0]  ONE_E = CW'(1);

  logic [CW-1:0] nfall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nfall <= '0;
      mode  <= FRM_SHORT;
    end else if (fs_fall) begin
      if (nfall == ONE_E)     mode <= FRM_SHORT;
      else if (nfall >= SAT)  mode <= FRM_LONG;
      nfall <= '0;
    end else if (bclk_fall && fs_lvl && nfall != SAT) begin
      nfall <= nfall + ONE_E;
    end
  end

  assign first_fall = (nfall == '0);
endmodule

// File: rtl/pcm_word_buffer.sv
module pcm_word_buffer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  input  logic         take,
  output logic [W-1:0] hold_word
);
  logic full;
  logic accept;

  assign in_ready = ~full;
  assign accept   = in_valid & ~full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full      <= 1'b0;
      hold_word <= '0;
    end else if (accept) begin
      full      <= 1'b1;
      hold_word <= in_data;
    end else if (take) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/pcm_tx_shifter.sv
module pcm_tx_shifter
  import pcm_tx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bclk_lvl,
  input  logic         bclk_rise,
  input  logic         bclk_fall,
  input  logic         fs_lvl,
  input  logic         fs_rise,
  input  logic         first_fall,
  input  frm_mode_e    mode,
  input  logic [W-1:0] word,
  output logic         take,
  output logic         sdata,
  output logic         sdata_oe
);
  localparam int            CW   = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W);
  localparam logic [CW-1:0] ONE_C = CW'(1);

  tx_state_e     st;
  logic [W-1:0]  sh;
  logic [CW-1:0] cnt;
  logic          start_s, start_l;

  assign start_s = (st == TX_IDLE) && (mode == FRM_SHORT) && bclk_fall && fs_lvl && first_fall;
  assign start_l = (st == TX_IDLE) && (mode == FRM_LONG) && fs_rise;
  assign take    = start_s | start_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= TX_IDLE;
      sh       <= '0;
      cnt      <= '0;
      sdata    <= 1'b0;
      sdata_oe <= 1'b0;
    end else begin
      case (st)
        TX_IDLE: begin
          if (start_s) begin
            sh <= word;
            st <= TX_ARM;
          end else if (start_l) begin
            if (bclk_lvl) begin
              sdata_oe <= 1'b1;
              sdata    <= word[W-1];
              sh       <= {word[W-2:0], 1'b0};
              cnt      <= ONE_C;
              st       <= TX_SHIFT;
            end else begin
              sh <= word;
              st <= TX_ARM;
            end
          end
        end
        TX_ARM: begin
          if (bclk_rise) begin
            sdata_oe <= 1'b1;
            sdata    <= sh[W-1];
            sh       <= {sh[W-2:0], 1'b0};
            cnt      <= ONE_C;
            st       <= TX_SHIFT;
          end
        end
        TX_SHIFT: begin
          if (bclk_rise && cnt < LAST) begin
            sdata <= sh[W-1];
            sh    <= {sh[W-2:0], 1'b0};
            cnt   <= cnt + ONE_C;
          end else if (bclk_fall && cnt == LAST) begin
            if (mode == FRM_LONG && fs_lvl) begin
              st <= TX_TAIL;
            end else begin
              sdata_oe <= 1'b0;
              sdata    <= 1'b0;
              st       <= TX_IDLE;
            end
          end
        end
        TX_TAIL: begin
          if (!fs_lvl) begin
            sdata_oe <= 1'b0;
            sdata    <= 1'b0;
            st       <= TX_IDLE;
          end
        end
        default: st <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pcm_tx_serializer.sv
module pcm_tx_serializer
  import pcm_tx_pkg::*;
#(
  parameter int WORD_W      = 8,
  parameter int LONG_MIN    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk,
  input  logic              fsync,
  input  logic              pcm_valid,
  input  logic [WORD_W-1:0] pcm_data,
  output logic              pcm_ready,
  output logic              sdata,
  output logic              sdata_oe
);
  logic bclk_lvl, bclk_rise, bclk_fall;
  logic fs_lvl, fs_rise, fs_fall;
  logic first_fall, take;
  frm_mode_e mode;
  logic [WORD_W-1:0] hold_word;

  pcm_edge_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync),
    .bclk_lvl(bclk_lvl), .bclk_rise(bclk_rise), .bclk_fall(bclk_fall),
    .fs_lvl(fs_lvl), .fs_rise(fs_rise), .fs_fall(fs_fall)
  );

  pcm_frame_mode_detect #(.LONG_MIN(LONG_MIN)) u_mode (
    .clk(clk), .rst_n(rst_n), .bclk_fall(bclk_fall), .fs_lvl(fs_lvl),
    .fs_fall(fs_fall), .mode(mode), .first_fall(first_fall)
  );

  pcm_word_buffer #(.W(WORD_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .in_valid(pcm_valid), .in_data(pcm_data),
    .in_ready(pcm_ready), .take(take), .hold_word(hold_word)
  );

  pcm_tx_shifter #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .bclk_lvl(bclk_lvl), .bclk_rise(bclk_rise),
    .bclk_fall(bclk_fall), .fs_lvl(fs_lvl), .fs_rise(fs_rise),
    .first_fall(first_fall), .mode(mode), .word(hold_word), .take(take),
    .sdata(sdata), .sdata_oe(sdata_oe)
  );
endmodule

// File: rtl/pcm_tx_serializer_chk.sv
module pcm_tx_serializer_chk (
  input logic clk,
  input logic rst_n,
  input logic sdata,
  input logic sdata_oe,
  input logic pcm_valid,
  input logic pcm_ready,
  input logic bclk_rise,
  input logic fs_rise
);
  // R7
  idle_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sdata_oe |-> !sdata);

  // R8
  slot_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pcm_valid && pcm_ready) |=> !pcm_ready);

  // R10
  bit_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdata_oe && $past(sdata_oe) && (sdata != $past(sdata))) |-> $past(bclk_rise));

  // R4
  enable_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdata_oe) |-> $past(bclk_rise || fs_rise));
endmodule

bind pcm_tx_serializer pcm_tx_serializer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sdata(sdata), .sdata_oe(sdata_oe),
  .pcm_valid(pcm_valid), .pcm_ready(pcm_ready),
  .bclk_rise(bclk_rise), .fs_rise(fs_rise)
);

// File: tb/tb_pcm_tx_serializer.sv
module tb_pcm_tx_serializer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bclk = 1'b0;
  logic       fsync = 1'b0;
  logic       pcm_valid = 1'b0;
  logic [7:0] pcm_data = 8'h00;
  logic       pcm_ready, sdata, sdata_oe;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  pcm_tx_serializer dut (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync),
    .pcm_valid(pcm_valid), .pcm_data(pcm_data), .pcm_ready(pcm_ready),
    .sdata(sdata), .sdata_oe(sdata_oe)
  );

  always #4 clk = ~clk;

  // kinds: 0 short, 1 long aligned, 2 long with sync before bit clock,
  //        3 long pulse (unchecked, trains long), 4 short pulse (unchecked, trains short)
  // fields: [18:16] kind, [15:12] sync length in bit periods, [7:0] word
  localparam logic [18:0] VEC [9] = '{
    {3'd0, 4'd1,  4'd0, 8'hA5},
    {3'd0, 4'd1,  4'd0, 8'h3C},
    {3'd0, 4'd1,  4'd0, 8'h81},
    {3'd3, 4'd3,  4'd0, 8'h00},
    {3'd1, 4'd3,  4'd0, 8'hC3},
    {3'd1, 4'd10, 4'd0, 8'h5A},
    {3'd2, 4'd4,  4'd0, 8'h96},
    {3'd4, 4'd1,  4'd0, 8'h00},
    {3'd0, 4'd1,  4'd0, 8'h7E}
  };

  task automatic chk(input logic act, input logic expv, input string tag, input string what);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, expv);
    end
  endtask

  task automatic halfp(input logic b, input logic f, input bit en,
                       input logic eo, input logic ed, input string tag);
    bclk  = b;
    fsync = f;
    repeat (4) @(negedge clk);
    if (en) begin
      chk(sdata_oe, eo, tag, "oe");
      chk(sdata, eo ? ed : 1'b0, tag, "data");
    end
  endtask

  task automatic short_frame(input logic [7:0] w, input bit en, input string tag);
    halfp(1'b1, 1'b1, en, 1'b0, 1'b0, tag);
    halfp(1'b0, 1'b1, en, 1'b0, 1'b0, tag);
    for (int p = 1; p <= 8; p++) begin
      halfp(1'b1, 1'b0, en, 1'b1, w[8-p], tag);
      halfp(1'b0, 1'b0, en, (p != 8), w[8-p], (p == 8) ? "R3" : tag);
    end
  endtask

  task automatic long_frame(input logic [7:0] w, input int len, input bit early,
                            input bit en, input string tag);
    int last;
    last = (len > 8) ? len : 8;
    if (early) begin
      bclk  = 1'b0;
      fsync = 1'b0;
      repeat (2) @(negedge clk);
      fsync = 1'b1;
      repeat (2) @(negedge clk);
      if (en) chk(sdata_oe, 1'b0, "R4", "oe before bit clock rise");
    end
    for (int p = 0; p <= last; p++) begin
      halfp(1'b1, (p < len), en, (p <= 7) ? 1'b1 : (p < len),
            (p <= 7) ? w[7-p] : w[0], (p <= 7) ? tag : "R5");
      halfp(1'b0, (p < len), en, (p < 7) ? 1'b1 : (p < len),
            (p <= 7) ? w[7-p] : w[0], (p < 7) ? tag : "R5");
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      halfp(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R7");
      halfp(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R7");
    end
  endtask

  task automatic load(input logic [7:0] w);
    chk(pcm_ready, 1'b1, "R8", "ready before load");
    pcm_valid = 1'b1;
    pcm_data  = w;
    @(negedge clk);
    pcm_valid = 1'b0;
    @(negedge clk);
    chk(pcm_ready, 1'b0, "R8", "ready after accept");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset values
    chk(sdata_oe, 1'b0, "R1", "oe in reset");
    chk(sdata, 1'b0, "R1", "data in reset");
    chk(pcm_ready, 1'b1, "R1", "ready in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(sdata_oe, 1'b0, "R1", "oe after reset");
    idle(1);

    for (int i = 0; i < 9; i++) begin
      logic [2:0] kind;
      logic [7:0] w;
      int len;
      kind = VEC[i][18:16];
      len  = int'(VEC[i][15:12]);
      w    = VEC[i][7:0];
      load(w);
      case (kind)
        3'd0: short_frame(w, 1'b1, (i == 8) ? "R6" : "R2 R10");
        3'd1: long_frame(w, len, 1'b0, 1'b1, (i == 4) ? "R6" : "R4");
        3'd2: long_frame(w, len, 1'b1, 1'b1, "R4");
        3'd3: long_frame(w, len, 1'b0, 1'b0, "R6");
        default: short_frame(w, 1'b0, "R6");
      endcase
      idle(2);
    end

    // R8: a full slot ignores a second offer
    load(8'h11);
    pcm_valid = 1'b1;
    pcm_data  = 8'h22;
    repeat (3) @(negedge clk);
    chk(pcm_ready, 1'b0, "R8", "ready while slot full");
    pcm_valid = 1'b0;
    short_frame(8'h11, 1'b1, "R8");
    chk(pcm_ready, 1'b1, "R8", "ready after frame start");
    idle(2);

    // R9: no new word, previous word repeats
    short_frame(8'h11, 1'b1, "R9");
    idle(2);

    // R1: reset in mid frame returns to short mode
    load(8'h33);
    long_frame(8'h33, 3, 1'b0, 1'b0, "R6");
    idle(2);
    load(8'h44);
    bclk  = 1'b1;
    fsync = 1'b1;
    repeat (4) @(negedge clk);
    chk(sdata_oe, 1'b1, "R4", "long enable before reset");
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(sdata_oe, 1'b0, "R1", "oe after mid-frame reset");
    chk(sdata, 1'b0, "R1", "data after mid-frame reset");
    chk(pcm_ready, 1'b1, "R1", "ready after mid-frame reset");
    bclk  = 1'b0;
    fsync = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    idle(1);
    load(8'h55);
    short_frame(8'h55, 1'b1, "R1 R6");
    idle(1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule